// File: doc/BRIEF.md
# Display link period sequencer

This block decides, pixel by pixel, which kind of period a display link carries on a line: plain control, the preamble ahead of a data island, the guard bands that frame an island, the island packet characters, the preamble ahead of video, the video guard band, or active video. It watches a horizontal pixel counter. It also takes the active width, the total line length and the number of packets to send on the line. These inputs may change from one line to the next.

The block produces a period code, the four control bits that signal a preamble, the fixed guard-band symbols for the three channels, and the auxiliary bits of channel 0: the sync pair, the guard marker and the island-start flag. Downstream encoders select between pixel encoding, packet encoding and these symbols using the period code. Every output is registered, so it describes the counter value that was presented one clock earlier.

An island is placed four pixels after active video ends. If it cannot fit while leaving twelve control characters before the video preamble, it is left out of that line.

Top module: `link_period_seq`

## Requirements
- R1: While `rst_n` is low, `period` is 0 (control) and `ctl`, all three symbol outputs and `aux0` are 0.
- R2: Every output reflects the `hcount` sampled one clock earlier. For `hcount < active_w`, `period` is 6 (video), and `ctl`, the symbols and `aux0` are 0.
- R3: For `hcount` from `line_w-10` to `line_w-3`, `period` is 4 (video preamble) and `ctl` is 4'b0001.
- R4: For `hcount` equal to `line_w-2` and `line_w-1`, `period` is 5 (video guard). `sym_ch0` and `sym_ch2` are 10'b1011001100 and `sym_ch1` is 10'b0100110011.
- R5: When an island is placed, `hcount` from `active_w+4` to `active_w+11` gives `period` 1 (island preamble) with `ctl` equal to 4'b0101.
- R6: An island is framed by guard pixels, `period` 2. The leading guard is at `active_w+12` and `active_w+13`, and the trailing guard is the two pixels right after the island. During guards, `sym_ch1` and `sym_ch2` are 10'b0100110011, `sym_ch0` is 0 and `aux0[3:2]` is 2'b11.
- R7: The island, `period` 3, starts at `active_w+14` and lasts 32 × `pkt_count` pixels. `aux0[3]` is 0 on its first pixel and 1 on every later pixel, and `aux0[2]` is 0.
- R8: In every period except video, `aux0[1:0]` equals {`vsync`, `hsync`} sampled together with `hcount`.
- R9: With `pkt_count` 0, the line carries control (`period` 0) from `active_w` up to `line_w-11`, with no preamble, guard or island.
- R10: When `active_w + 32×pkt_count + 38 > line_w`, no island, island preamble or island guard is emitted on that line; those pixels stay control.
- R11: In control, `ctl` and all symbol outputs are 0 and `aux0[3:2]` is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hcount | input | XW | Horizontal pixel position, 0 = first active pixel |
| active_w | input | XW | Number of active video pixels on the line |
| line_w | input | XW | Total pixels per line |
| pkt_count | input | PW | Packets to send in this line's island |
| hsync | input | 1 | Horizontal sync level |
| vsync | input | 1 | Vertical sync level |
| period | output | 3 | 0 control, 1 island preamble, 2 island guard, 3 island, 4 video preamble, 5 video guard, 6 video |
| ctl | output | 4 | Preamble control bits |
| sym_ch0 | output | 10 | Guard symbol, channel 0 |
| sym_ch1 | output | 10 | Guard symbol, channel 1 |
| sym_ch2 | output | 10 | Guard symbol, channel 2 |
| aux0 | output | 4 | Channel 0 auxiliary bits: island-continue, guard, vsync, hsync |

## Verification
The bench keeps the default widths of 12 counter bits and 3 packet-count bits. These widths allow a packet count of up to seven and lines of several hundred pixels. Short lines of 140 to 200 pixels with 40 active pixels let a single run cover several cases: an empty island, one to three packets, an island that fits with no spare pixel, and one that misses by two pixels and must be dropped. The sync inputs toggle inside every period, so the sideband path is seen next to each guard and island character.

// File: rtl/link_period_seq.sv
module link_period_seq #(
  parameter int XW = 12,
  parameter int PW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [XW-1:0] hcount,
  input  logic [XW-1:0] active_w,
  input  logic [XW-1:0] line_w,
  input  logic [PW-1:0] pkt_count,
  input  logic          hsync,
  input  logic          vsync,
  output logic [2:0]    period,
  output logic [3:0]    ctl,
  output logic [9:0]    sym_ch0,
  output logic [9:0]    sym_ch1,
  output logic [9:0]    sym_ch2,
  output logic [3:0]    aux0
);
  localparam int CW = XW + PW + 7;
  localparam logic [2:0] P_CTRL = 3'd0, P_IPRE = 3'd1, P_IGRD = 3'd2, P_ISL = 3'd3,
                         P_VPRE = 3'd4, P_VGRD = 3'd5, P_VID = 3'd6;
  localparam logic [9:0] GB_A = 10'b1011001100, GB_B = 10'b0100110011;

  logic [CW-1:0] x, w, t, isl_len, isl_s, isl_e;
  logic          fits;
  logic [2:0]    nxt;

  assign x       = CW'(hcount);
  assign w       = CW'(active_w);
  assign t       = CW'(line_w);
  assign isl_len = CW'(pkt_count) << 5;
  assign isl_s   = w + CW'(14);
  assign isl_e   = isl_s + isl_len;
  assign fits    = (pkt_count != '0) && (w + isl_len + CW'(38) <= t);

  always_comb begin
    nxt = P_CTRL;
    if (x < w)                                  nxt = P_VID;
    else if (x >= t - CW'(2) && x < t)          nxt = P_VGRD;
    else if (x >= t - CW'(10) && x < t)         nxt = P_VPRE;
    else if (fits) begin
      if (x >= w + CW'(4) && x < w + CW'(12))   nxt = P_IPRE;
      else if (x >= w + CW'(12) && x < isl_s)   nxt = P_IGRD;
      else if (x >= isl_s && x < isl_e)         nxt = P_ISL;
      else if (x >= isl_e && x < isl_e + CW'(2)) nxt = P_IGRD;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      period <= P_CTRL;
      ctl    <= '0;
      sym_ch0 <= '0;
      sym_ch1 <= '0;
      sym_ch2 <= '0;
      aux0   <= '0;
    end else begin
      period  <= nxt;
      ctl     <= (nxt == P_IPRE) ? 4'b0101 : (nxt == P_VPRE) ? 4'b0001 : 4'b0000;
      sym_ch0 <= (nxt == P_VGRD) ? GB_A : '0;
      sym_ch1 <= (nxt == P_VGRD || nxt == P_IGRD) ? GB_B : '0;
      sym_ch2 <= (nxt == P_VGRD) ? GB_A : (nxt == P_IGRD) ? GB_B : '0;
      case (nxt)
        P_VID:   aux0 <= '0;
        P_ISL:   aux0 <= {x != isl_s, 1'b0, vsync, hsync};
        P_IGRD:  aux0 <= {2'b11, vsync, hsync};
        default: aux0 <= {2'b00, vsync, hsync};
      endcase
    end
  end

  a_r3_vpre_ctl: assert property (@(posedge clk) disable iff (!rst_n)
    period == P_VPRE |-> ctl == 4'b0001);
  a_r5_ipre_ctl: assert property (@(posedge clk) disable iff (!rst_n)
    period == P_IPRE |-> ctl == 4'b0101);
  a_r6_guard_marker: assert property (@(posedge clk) disable iff (!rst_n)
    period == P_IGRD |-> aux0[3:2] == 2'b11 && sym_ch0 == '0);
  a_r6_trailing_guard: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(period == P_ISL) |-> period == P_IGRD);
  a_r11_ctrl_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    period == P_CTRL |-> ctl == 4'b0000 && sym_ch1 == '0 && aux0[3:2] == 2'b00);
  a_r2_video_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    period == P_VID |-> aux0 == '0 && ctl == '0);
endmodule

// File: tb/sim_link_period_seq.sv
`timescale 1ns/1ps
module sim_link_period_seq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [11:0] hcount = '0, active_w = 12'd40, line_w = 12'd140;
  logic [2:0] pkt_count = '0;
  logic hsync = 1'b0, vsync = 1'b0;
  logic [2:0] period;
  logic [3:0] ctl, aux0;
  logic [9:0] sym_ch0, sym_ch1, sym_ch2;
  int checks = 0, errors = 0;
  bit have_exp = 0;
  int e_per, e_aux;
  string e_tag;

  always #2.5 clk = ~clk;

  link_period_seq #(.XW(12), .PW(3)) u0 (.clk, .rst_n, .hcount, .active_w, .line_w, .pkt_count,
    .hsync, .vsync, .period, .ctl, .sym_ch0, .sym_ch1, .sym_ch2, .aux0);

  function automatic int ref_period(int x, int w, int t, int n);
    int s;
    bit ok;
    ok = n > 0 && w + 32 * n + 38 <= t;
    s = w + 14;
    if (x < w) return 6;
    if (x >= t - 2) return 5;
    if (x >= t - 10) return 4;
    if (!ok) return 0;
    if (x >= w + 4 && x < w + 12) return 1;
    if (x >= w + 12 && x < s) return 2;
    if (x >= s && x < s + 32 * n) return 3;
    if (x >= s + 32 * n && x < s + 32 * n + 2) return 2;
    return 0;
  endfunction

  function automatic string tag_of(int p, string ctrl_tag);
    case (p)
      1: return "R5";
      2: return "R6";
      3: return "R7";
      4: return "R3";
      5: return "R4";
      6: return "R2";
      default: return ctrl_tag;
    endcase
  endfunction

  task automatic compare();
    logic [37:0] act, exp;
    logic [3:0] ec;
    logic [9:0] e0, e1, e2;
    ec = (e_per == 1) ? 4'b0101 : (e_per == 4) ? 4'b0001 : 4'b0000;
    e0 = (e_per == 5) ? 10'b1011001100 : 10'd0;
    e1 = (e_per == 5 || e_per == 2) ? 10'b0100110011 : 10'd0;
    e2 = (e_per == 5) ? 10'b1011001100 : (e_per == 2) ? 10'b0100110011 : 10'd0;
    act = {1'b0, period, ctl, sym_ch0, sym_ch1, sym_ch2};
    exp = {1'b0, 3'(e_per), ec, e0, e1, e2};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s period/ctl/symbols actual=%h expected=%h", tag_of(e_per, e_tag), act, exp);
    end
    checks++;
    if (aux0 !== 4'(e_aux)) begin
      errors++;
      $display("FAIL %s aux0 actual=%b expected=%b", (e_per == 3) ? "R7" : "R8", aux0, 4'(e_aux));
    end
  endtask

  task automatic run_line(int w, int t, int n, int li, string ctrl_tag);
    for (int x = 0; x < t; x++) begin
      @(negedge clk);
      if (have_exp) compare();
      hcount = 12'(x); active_w = 12'(w); line_w = 12'(t); pkt_count = 3'(n);
      hsync = x[3] ^ x[0]; vsync = li[0] ^ x[2];
      e_per = ref_period(x, w, t, n);
      if (e_per == 6) e_aux = 0;
      else if (e_per == 3) e_aux = {(x != w + 14) ? 1 : 0, 1'b0, vsync, hsync};
      else if (e_per == 2) e_aux = {2'b11, vsync, hsync};
      else e_aux = {2'b00, vsync, hsync};
      e_tag = ctrl_tag;
      have_exp = 1;
    end
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if ({period, ctl, sym_ch0, sym_ch1, sym_ch2, aux0} !== '0) begin
      errors++;
      $display("FAIL R1 reset outputs actual=%h expected=0",
               {period, ctl, sym_ch0, sym_ch1, sym_ch2, aux0});
    end
    @(negedge clk) rst_n = 1'b1;
    run_line(40, 140, 0, 0, "R9");
    run_line(40, 140, 1, 1, "R11");
    run_line(40, 140, 2, 2, "R10");
    run_line(40, 142, 2, 3, "R11");
    run_line(40, 180, 2, 4, "R11");
    run_line(40, 200, 3, 5, "R11");
    run_line(40, 173, 3, 6, "R10");
    run_line(64, 300, 7, 7, "R11");
    @(negedge clk);
    compare();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule